// File: doc/BRIEF.md
# Two-Lane Byte Serializer with Strobe Spacing

This block is the master-side transmitter of a synchronous point-to-point link. Both ends share one clock. Bytes arrive over a valid/ready handshake. Each byte carries a flag that marks it as the opening byte of a superframe. The block sends every accepted byte over a two-bit data bus in four consecutive clock cycles, starting with the most significant pair.

Alongside the first pair, a one-cycle byte strobe marks the byte boundary. A frame strobe accompanies that byte strobe when the byte opens a superframe. Successive byte strobes are kept a minimum number of cycles apart. Upstream flow is held back through the ready signal until the spacing has elapsed.

A controller-driven enable gates the whole link. While the enable is low, nothing is driven, nothing is accepted, and a byte that was in flight is dropped. A design that carries two independent streams uses one instance per stream.

Top module: `ls_pair_tx`

## Requirements
- R1: An accepted byte b[7:0] appears on `lnk_data` over four consecutive cycles as the pairs {b7,b6}, {b5,b4}, {b3,b2}, {b1,b0}, in that order. Lane 1 (`lnk_data[1]`) carries the odd-numbered bit and lane 0 carries the even-numbered bit.
- R2: `lnk_strobe` is a one-cycle pulse in the cycle right after the acceptance edge, and it coincides with the first pair. It is low during the other three pairs.
- R3: `lnk_frame` is high only while `lnk_strobe` is high. It is high exactly when the accepted byte had `in_sof` set.
- R4: Two rising strobes on `lnk_strobe` are never fewer than MIN_GAP (default 8) cycles apart.
- R5: `in_ready` is low while a byte is still being shifted out and until MIN_GAP edges have passed since the last acceptance. A byte is taken only on an edge where `in_valid` and `in_ready` are both high.
- R6: While `link_en` is low, `lnk_data` is zero, `lnk_strobe`, `lnk_frame` and `in_ready` are low, and any byte in progress is discarded. Its remaining pairs are not sent after the enable returns.
- R7: When no byte is being sent, `lnk_data` is zero.
- R8: During reset (`rst_n` low) all link outputs are zero. After reset, `in_ready` equals `link_en`.
- R9: With `in_valid` held high and the link enabled, byte strobes occur exactly MIN_GAP cycles apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared link clock; outputs launch on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_en | input | 1 | Link enable from the controller |
| in_valid | input | 1 | Upstream byte offered |
| in_data | input | BYTE_W | Byte to transmit |
| in_sof | input | 1 | Byte opens a superframe |
| in_ready | output | 1 | Block can accept a byte on this edge |
| lnk_data | output | LANE_W | Serial data pair |
| lnk_strobe | output | 1 | Byte-boundary strobe |
| lnk_frame | output | 1 | Superframe-start strobe |

## Verification
The bench uses the default parameters: an 8-bit byte, two lanes and a spacing of 8 cycles. With these values the spacing timer, rather than the four-cycle shift, decides when `in_ready` returns, so the rule that throttles throughput is the one under test. The four-beat shift is short enough that an enable drop can be placed on any pair of a byte. Random enable dropouts, random valid gaps and random superframe flags mix with directed cases: a known bit pattern, back-to-back traffic and a drop in the middle of a byte.

// File: rtl/ls_pkg.sv
package ls_pkg;

  // Effective strobe spacing: never shorter than the time one byte occupies the lanes.
  function automatic int unsigned gap_len(input int unsigned min_gap, input int unsigned beats);
    return (min_gap > beats) ? min_gap : beats;
  endfunction

  function automatic int unsigned cnt_width(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction

endpackage

// File: rtl/ls_gap_timer.sv
module ls_gap_timer
  import ls_pkg::*;
#(
  parameter int unsigned GAP = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic idle
);
  localparam int unsigned CW = cnt_width(GAP);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = CW'(GAP - 1);
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign idle = (cnt_q == '0);
endmodule

// File: rtl/ls_serializer.sv
module ls_serializer
  import ls_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned LANE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_en,
  input  logic              load,
  input  logic [BYTE_W-1:0] din,
  input  logic              sof,
  output logic [LANE_W-1:0] lane,
  output logic              first,
  output logic              frame,
  output logic              busy
);
  localparam int unsigned BEATS = BYTE_W / LANE_W;
  localparam int unsigned BW    = cnt_width(BEATS);

  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [BW-1:0]     beats_q, beats_d;
  logic              first_q, first_d;
  logic              sof_q, sof_d;
  logic              active;

  always_comb begin
    sh_d    = sh_q;
    beats_d = beats_q;
    first_d = 1'b0;
    sof_d   = 1'b0;
    if (!link_en) begin
      sh_d    = '0;
      beats_d = '0;
    end else if (load) begin
      sh_d    = din;
      beats_d = BW'(BEATS);
      first_d = 1'b1;
      sof_d   = sof;
    end else if (beats_q != '0) begin
      sh_d    = sh_q << LANE_W;
      beats_d = beats_q - 1'b1;
    end else begin
      sh_d    = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      beats_q <= '0;
      first_q <= 1'b0;
      sof_q   <= 1'b0;
    end else begin
      sh_q    <= sh_d;
      beats_q <= beats_d;
      first_q <= first_d;
      sof_q   <= sof_d;
    end
  end

  assign active = (beats_q != '0) && link_en;

  // Top pair of the shift register; lane g takes bit (BYTE_W-LANE_W+g).
  for (genvar g = 0; g < LANE_W; g++) begin : g_lane
    assign lane[g] = active & sh_q[BYTE_W-LANE_W+g];
  end

  assign first = first_q & active;
  assign frame = first_q & sof_q & active;
  assign busy  = (beats_q > BW'(1));
endmodule

// File: rtl/ls_pair_tx.sv
module ls_pair_tx
  import ls_pkg::*;
#(
  parameter int unsigned BYTE_W  = 8,
  parameter int unsigned LANE_W  = 2,
  parameter int unsigned MIN_GAP = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_en,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_sof,
  output logic              in_ready,
  output logic [LANE_W-1:0] lnk_data,
  output logic              lnk_strobe,
  output logic              lnk_frame
);
  localparam int unsigned BEATS = BYTE_W / LANE_W;
  localparam int unsigned GAP   = gap_len(MIN_GAP, BEATS);

  logic gap_idle;
  logic ser_busy;
  logic accept;

  assign in_ready = link_en & gap_idle & ~ser_busy;
  assign accept   = in_valid & in_ready;

  ls_gap_timer #(.GAP(GAP)) u_gap (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept),
    .idle  (gap_idle)
  );

  ls_serializer #(.BYTE_W(BYTE_W), .LANE_W(LANE_W)) u_ser (
    .clk     (clk),
    .rst_n   (rst_n),
    .link_en (link_en),
    .load    (accept),
    .din     (in_data),
    .sof     (in_sof),
    .lane    (lnk_data),
    .first   (lnk_strobe),
    .frame   (lnk_frame),
    .busy    (ser_busy)
  );
endmodule

// File: rtl/ls_pair_tx_chk.sv
module ls_pair_tx_chk #(
  parameter int unsigned LANE_W  = 2,
  parameter int unsigned MIN_GAP = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              link_en,
  input logic              in_valid,
  input logic              in_ready,
  input logic [LANE_W-1:0] lnk_data,
  input logic              lnk_strobe,
  input logic              lnk_frame
);
  localparam int unsigned SW = $clog2(MIN_GAP + 2);

  logic [SW-1:0] since_q;
  logic          seen_q;

  // Cycles since the last strobe, saturating at MIN_GAP.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q <= '0;
      seen_q  <= 1'b0;
    end else if (lnk_strobe) begin
      since_q <= SW'(1);
      seen_q  <= 1'b1;
    end else if (since_q < SW'(MIN_GAP)) begin
      since_q <= since_q + 1'b1;
    end
  end

  assert_strobe_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lnk_strobe && seen_q) |-> (since_q >= SW'(MIN_GAP)));

  assert_frame_inside_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lnk_frame |-> lnk_strobe);

  assert_disabled_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !link_en |-> (lnk_data == '0 && !lnk_strobe && !lnk_frame && !in_ready));

  assert_strobe_follows_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (!link_en || lnk_strobe));

  assert_strobe_single_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lnk_strobe |=> !lnk_strobe);

  assert_no_ready_on_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lnk_strobe |-> !in_ready);
endmodule

bind ls_pair_tx ls_pair_tx_chk #(.LANE_W(LANE_W), .MIN_GAP(MIN_GAP)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .link_en    (link_en),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .lnk_data   (lnk_data),
  .lnk_strobe (lnk_strobe),
  .lnk_frame  (lnk_frame)
);

// File: tb/sim_ls_pair_tx.sv
`timescale 1ns/1ps
module sim_ls_pair_tx;
  localparam int unsigned MIN_GAP = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       link_en;
  logic       in_valid;
  logic [7:0] in_data;
  logic       in_sof;
  logic       in_ready;
  logic [1:0] lnk_data;
  logic       lnk_strobe;
  logic       lnk_frame;

  int n_chk  = 0;
  int n_fail = 0;
  bit run = 1'b0;
  bit cont_phase = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ls_pair_tx #(.BYTE_W(8), .LANE_W(2), .MIN_GAP(MIN_GAP)) u0 (
    .clk(clk), .rst_n(rst_n), .link_en(link_en), .in_valid(in_valid),
    .in_data(in_data), .in_sof(in_sof), .in_ready(in_ready),
    .lnk_data(lnk_data), .lnk_strobe(lnk_strobe), .lnk_frame(lnk_frame)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] pair_of(input logic [7:0] b, input int idx);
    return {b[7 - 2*idx], b[6 - 2*idx]};
  endfunction

  // Bench model, updated on every falling edge.
  bit         acc_prev = 1'b0;
  logic [7:0] acc_byte = '0;
  bit         acc_sof  = 1'b0;
  logic [7:0] cur      = '0;
  int         rem      = 0;
  int         since    = 1000;
  int         cyc      = 0;
  int         last_stb = -1;

  always @(negedge clk) begin
    if (run) begin
      cyc++;
      if (!link_en) begin
        chk(lnk_data == 2'b00, "R6 data", lnk_data, 0);
        chk(!lnk_strobe && !lnk_frame, "R6 strobes", {lnk_strobe, lnk_frame}, 0);
        rem = 0;
      end else if (acc_prev) begin
        chk(lnk_strobe, "R2 strobe after accept", lnk_strobe, 1);
        chk(lnk_frame == acc_sof, "R3 frame", lnk_frame, acc_sof);
        chk(lnk_data == pair_of(acc_byte, 0), "R1 pair0", lnk_data, pair_of(acc_byte, 0));
        cur = acc_byte;
        rem = 3;
      end else if (rem > 0) begin
        chk(lnk_data == pair_of(cur, 4 - rem), "R1 pair", lnk_data, pair_of(cur, 4 - rem));
        chk(!lnk_strobe && !lnk_frame, "R2 strobe low", {lnk_strobe, lnk_frame}, 0);
        rem--;
      end else begin
        chk(lnk_data == 2'b00, "R7 idle data", lnk_data, 0);
        chk(!lnk_strobe && !lnk_frame, "R7 idle strobes", {lnk_strobe, lnk_frame}, 0);
      end
      if (acc_prev) since = 0; else since++;
      if (lnk_strobe) begin
        if (cont_phase && last_stb >= 0)
          chk(cyc - last_stb == MIN_GAP, "R9 back-to-back spacing", cyc - last_stb, MIN_GAP);
        last_stb = cyc;
      end
      chk(in_ready == (link_en && since >= MIN_GAP - 1), "R5 ready",
          in_ready, (link_en && since >= MIN_GAP - 1));
      acc_prev = in_valid && in_ready;
      acc_byte = in_data;
      acc_sof  = in_sof;
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; link_en = 1'b1; in_valid = 1'b0; in_data = '0; in_sof = 1'b0;
    step(2);
    @(negedge clk);
    chk(lnk_data == 0 && !lnk_strobe && !lnk_frame, "R8 reset outputs",
        {lnk_data, lnk_strobe, lnk_frame}, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    run = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R8 ready after reset", in_ready, 1);

    // Directed pattern 0xB4 with superframe flag: pairs 2,3,1,0 (R1, R3).
    @(posedge clk); #1;
    in_valid = 1'b1; in_data = 8'hB4; in_sof = 1'b1;
    step(1);
    in_valid = 1'b0; in_sof = 1'b0;
    step(12);

    // Back-to-back traffic (R9, R4).
    cont_phase = 1'b1; last_stb = -1;
    in_valid = 1'b1;
    for (int i = 0; i < 60; i++) begin
      in_data = 8'($urandom); in_sof = ($urandom % 4) == 0;
      step(1);
    end
    in_valid = 1'b0;
    cont_phase = 1'b0;
    step(10);

    // Enable drop on the second pair of a byte (R6).
    in_valid = 1'b1; in_data = 8'hFF; in_sof = 1'b0;
    step(1);
    in_valid = 1'b0;
    step(1);
    link_en = 1'b0;
    step(1);
    link_en = 1'b1;
    step(12);

    // Constrained random mix.
    for (int i = 0; i < 4000; i++) begin
      in_valid = ($urandom % 3) != 0;
      in_data  = 8'($urandom);
      in_sof   = ($urandom % 5) == 0;
      link_en  = ($urandom % 25) != 0;
      step(1);
    end
    link_en = 1'b1; in_valid = 1'b0;
    step(12);
    run = 1'b0;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got %0h expected %0h", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule